// File: doc/BRIEF.md
# Decimating Six-Channel Pixel Input Sequencer

This block accepts a stream of 10-bit pixel words on a single parallel bus and deals consecutive words out to six channels, one word per sampling edge. Each channel is double buffered: a fill register collects the incoming word, and a hold register drives the channel output. One strobe restarts the dealing sequence. A second strobe copies all six fill registers into the hold registers on the same edge, so the six outputs always change together.

A direction input chooses whether a sequence fills channel 0 first and works upward, or channel 5 first and works downward. An edge-select input chooses whether inputs are sampled on the rising or the falling clock edge. A polarity flag travels with the held words, and it changes only on a copy edge. After six words the sequencer stops. Any further word is dropped and raises a sticky overflow flag until the next start. A typical use drives the six outputs from the previous group of pixels while the next group loads.

Top module: `pxs_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, all fill and hold registers, `pol_o` and `ovf_o` clear to 0, and the sequencer goes idle. A valid word that arrives after reset without a start is not stored, and it sets `ovf_o`.
- R2: When `start_i` is sampled high, the sequence restarts and `ovf_o` clears. The valid word sampled on that same edge, if any, goes to the first channel. Each later valid word goes to the next channel. Edges with `vld_i` low do not advance the sequence.
- R3: `dir_i` is sampled together with `start_i` and is held for the whole sequence. With 0 the fill order is channel 0,1,2,3,4,5. With 1 it is 5,4,3,2,1,0.
- R4: A word written into a fill register does not reach `chan_o` until a copy edge.
- R5: When `xfer_i` is sampled high, all six hold registers load their fill registers on one edge. Without `xfer_i`, `chan_o` keeps its value. Channel k is `chan_o[k*10 +: 10]`.
- R6: When a copy and a word write fall on the same edge, the hold registers receive the fill contents from before that write. The new word appears at the next copy.
- R7: Once six words have been accepted, further valid words leave every fill register unchanged and set `ovf_o`. `ovf_o` stays high until the next start or reset.
- R8: `inv_i` is captured into `pol_o` only on an edge where `xfer_i` is sampled high. At other times `pol_o` holds.
- R9: With `edge_sel_i` = 1, inputs are sampled at the rising edge. With 0, they are sampled at the falling edge, and the result shows on the outputs after the following rising edge. Changes to the inputs between that falling edge and that rising edge have no effect.
- R10: A start during an unfinished sequence sends its word to the first channel again. It also resets the count, so six more words are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_sel_i | input | 1 | 1: sample on rising edge, 0: on falling edge |
| dir_i | input | 1 | Fill order, captured with start |
| start_i | input | 1 | Restart sequence strobe |
| xfer_i | input | 1 | Copy fill registers to hold registers |
| inv_i | input | 1 | Polarity request, captured on copy |
| vld_i | input | 1 | Pixel word valid |
| pix_i | input | 10 | Pixel word |
| chan_o | output | 60 | Six held words, channel k at bits k*10+9:k*10 |
| pol_o | output | 1 | Polarity flag for the held words |
| ovf_o | output | 1 | Sticky overflow: word dropped while not filling |

## Verification
The hardest cases to reach are a copy on the same edge as a word write, and words arriving after the sixth. In both, the fill registers cannot be seen directly. The stimulus therefore completes a known group and then pushes either an overlapping write with a copy or a seventh word with a distinct value. A later bare copy then shows the exact fill contents on the outputs. For falling-edge mode, the bench changes the pixel bus after the falling edge and before the rising edge, which shows that the falling-edge sample is the one that counts.

// File: rtl/pxs_pkg.sv
// Shared types for the pixel input sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package pxs_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_FILL = 1'b1
    } seq_state_t;
endpackage

// File: rtl/pxs_edge_capture.sv
// Selects the sampling edge for all pixel-bus inputs.
// A falling-edge register bank captures the inputs; the rising-edge logic
// downstream takes either the live inputs (edge_sel_i=1) or that bank (0).
// Assumes: edge_sel_i changes only while the strobes and vld_i are low.
module pxs_edge_capture #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_sel_i,
    input  logic              dir_i,
    input  logic              start_i,
    input  logic              xfer_i,
    input  logic              inv_i,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic              dir_s,
    output logic              start_s,
    output logic              xfer_s,
    output logic              inv_s,
    output logic              vld_s,
    output logic [DATA_W-1:0] pix_s
);
    logic              dir_n, start_n, xfer_n, inv_n, vld_n;
    logic [DATA_W-1:0] pix_n;

    // Falling-edge capture of every input used in falling-edge mode.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            dir_n   <= 1'b0;
            start_n <= 1'b0;
            xfer_n  <= 1'b0;
            inv_n   <= 1'b0;
            vld_n   <= 1'b0;
            pix_n   <= '0;
        end else begin
            dir_n   <= dir_i;
            start_n <= start_i;
            xfer_n  <= xfer_i;
            inv_n   <= inv_i;
            vld_n   <= vld_i;
            pix_n   <= pix_i;
        end
    end

    // Pick the live or the falling-edge copy for the rising-edge logic.
    always_comb begin
        if (edge_sel_i) begin
            dir_s   = dir_i;
            start_s = start_i;
            xfer_s  = xfer_i;
            inv_s   = inv_i;
            vld_s   = vld_i;
            pix_s   = pix_i;
        end else begin
            dir_s   = dir_n;
            start_s = start_n;
            xfer_s  = xfer_n;
            inv_s   = inv_n;
            vld_s   = vld_n;
            pix_s   = pix_n;
        end
    end
endmodule

// File: rtl/pxs_fill_ctrl.sv
// Fill sequencer: tracks how many words the current sequence has taken,
// the latched fill direction, and the sticky overflow flag; produces a
// one-hot write enable for the channel fill registers.
// Assumes: NUM_CH >= 2; all inputs already sampled on the chosen edge.
module pxs_fill_ctrl
    import pxs_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              vld_i,
    input  logic              dir_i,
    output logic [NUM_CH-1:0] wr_en_o,
    output logic              ovf_o
);
    localparam int PTR_W = $clog2(NUM_CH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CH - 1);

    seq_state_t       state;
    logic [PTR_W-1:0] ptr;
    logic             dir_q;
    logic [PTR_W-1:0] slot;
    logic [PTR_W-1:0] idx;
    logic             accept;

    // Position in the sequence for the word on this edge.
    always_comb begin
        slot   = start_i ? '0 : ptr;
        accept = vld_i && (start_i || state == SEQ_FILL);
        if (start_i ? dir_i : dir_q)
            idx = LAST - slot;
        else
            idx = slot;
    end

    // One-hot write enable for the addressed channel.
    always_comb begin
        wr_en_o = '0;
        for (int k = 0; k < NUM_CH; k++)
            if (accept && idx == PTR_W'(k))
                wr_en_o[k] = 1'b1;
    end

    // Sequence state, count, direction and overflow update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            ptr   <= '0;
            dir_q <= 1'b0;
            ovf_o <= 1'b0;
        end else if (start_i) begin
            dir_q <= dir_i;
            ovf_o <= 1'b0;
            state <= SEQ_FILL;
            ptr   <= vld_i ? PTR_W'(1) : '0;
        end else if (vld_i) begin
            if (state == SEQ_FILL) begin
                if (ptr == LAST) begin
                    state <= SEQ_IDLE;
                    ptr   <= '0;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end else begin
                ovf_o <= 1'b1;
            end
        end
    end

    // R2
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_o));

    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(vld_i && !start_i && state == SEQ_IDLE));

    // R10
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

    // R2
    start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !ovf_o);
endmodule

// File: rtl/pxs_channel.sv
// One double-buffered channel: a fill register written by the sequencer
// and a hold register loaded from it on a copy strobe.
// Assumes: wr_en_i and xfer_i are sampled on the chosen edge.
module pxs_channel #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              xfer_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic [DATA_W-1:0] hold_o
);
    logic [DATA_W-1:0] fill_q;

    // Fill register: collects the word addressed to this channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else if (wr_en_i)
            fill_q <= pix_i;
    end

    // Hold register: takes the fill value as it was before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_o <= '0;
        else if (xfer_i)
            hold_o <= fill_q;
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_i |=> $stable(hold_o));

    // R6
    hold_prior_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> hold_o == $past(fill_q));
endmodule

// File: rtl/pxs_sequencer.sv
// Top of the decimating six-channel pixel input sequencer: edge selection,
// fill sequencing, per-channel double buffers and the polarity flag.
// Assumes: one pixel word per sampling edge at most; edge_sel_i changed
// only while the bus is quiet.
module pxs_sequencer #(
    parameter int DATA_W = 10,
    parameter int NUM_CH = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     edge_sel_i,
    input  logic                     dir_i,
    input  logic                     start_i,
    input  logic                     xfer_i,
    input  logic                     inv_i,
    input  logic                     vld_i,
    input  logic [DATA_W-1:0]        pix_i,
    output logic [NUM_CH*DATA_W-1:0] chan_o,
    output logic                     pol_o,
    output logic                     ovf_o
);
    logic              dir_s, start_s, xfer_s, inv_s, vld_s;
    logic [DATA_W-1:0] pix_s;
    logic [NUM_CH-1:0] wr_en;

    pxs_edge_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_sel_i (edge_sel_i),
        .dir_i      (dir_i),
        .start_i    (start_i),
        .xfer_i     (xfer_i),
        .inv_i      (inv_i),
        .vld_i      (vld_i),
        .pix_i      (pix_i),
        .dir_s      (dir_s),
        .start_s    (start_s),
        .xfer_s     (xfer_s),
        .inv_s      (inv_s),
        .vld_s      (vld_s),
        .pix_s      (pix_s)
    );

    pxs_fill_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_s),
        .vld_i   (vld_s),
        .dir_i   (dir_s),
        .wr_en_o (wr_en),
        .ovf_o   (ovf_o)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        pxs_channel #(.DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en_i (wr_en[k]),
            .xfer_i  (xfer_s),
            .pix_i   (pix_s),
            .hold_o  (chan_o[k*DATA_W +: DATA_W])
        );
    end

    // Polarity flag follows the held words and moves only on a copy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_o <= 1'b0;
        else if (xfer_s)
            pol_o <= inv_s;
    end

    // R8
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_s |=> $stable(pol_o));
endmodule

// File: tb/pxs_sequencer_tb.sv
module pxs_sequencer_tb;
    localparam int W  = 10;
    localparam int NC = 6;

    logic clk = 1'b0;
    logic rst_n, edge_sel, dir, start, xfer, inv, vld;
    logic [W-1:0] pix;
    logic [NC*W-1:0] chan;
    logic pol, ovf;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pxs_sequencer #(.DATA_W(W), .NUM_CH(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .edge_sel_i(edge_sel), .dir_i(dir),
        .start_i(start), .xfer_i(xfer), .inv_i(inv), .vld_i(vld),
        .pix_i(pix), .chan_o(chan), .pol_o(pol), .ovf_o(ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare all six channels against an expected array.
    task automatic chk_all(input string req, input int e [NC]);
        for (int k = 0; k < NC; k++)
            chk(req, int'(chan[k*W +: W]), e[k]);
    endtask

    // One sampling edge; ends 1 ns after the rising edge that applies it.
    task automatic cyc(input logic v, input int d, input logic st,
                       input logic xf, input logic dr, input logic iv);
        if (edge_sel) begin
            @(negedge clk);
            vld = v; pix = W'(d); start = st; xfer = xf; dir = dr; inv = iv;
            @(posedge clk); #1;
        end else begin
            vld = v; pix = W'(d); start = st; xfer = xf; dir = dr; inv = iv;
            @(negedge clk); #1;
            pix = ~W'(d); inv = ~iv; dir = ~dr;
            @(posedge clk); #1;
        end
        vld = 0; start = 0; xfer = 0;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        int z [NC] = '{default: 0};
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        chk_all("R1 reset", z);
        chk("R1 pol", int'(pol), 0);
        chk("R1 ovf", int'(ovf), 0);
        rst_n = 1;
        cyc(1, 77, 0, 0, 0, 0);
        chk("R1 idle ovf", int'(ovf), 1);
        cyc(0, 0, 0, 1, 0, 0);
        chk_all("R1 word not stored", z);
    endtask

    // Forward fill, gaps, invisible before copy, then copy.
    task automatic t_forward();
        int e [NC];
        int z [NC] = '{default: 0};
        cyc(1, 100, 1, 0, 0, 0);
        chk("R2 start clears ovf", int'(ovf), 0);
        for (int k = 1; k < NC; k++) begin
            idle();
            cyc(1, 100 + k, 0, 0, 0, 0);
        end
        chk_all("R4 fill hidden", z);
        cyc(0, 0, 0, 1, 0, 0);
        for (int k = 0; k < NC; k++) e[k] = 100 + k;
        chk_all("R2 R3 forward order", e);
        idle();
        chk_all("R5 hold stable", e);
    endtask

    task automatic t_reverse();
        int e [NC];
        cyc(1, 200, 1, 0, 1, 0);
        for (int k = 1; k < NC; k++) cyc(1, 200 + k, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        for (int k = 0; k < NC; k++) e[k] = 205 - k;
        chk_all("R3 reverse order", e);
    endtask

    // Copy on the same edge as a write: old contents move out.
    task automatic t_overlap();
        int e [NC];
        for (int k = 0; k < NC; k++) cyc(1, 300 + k, k == 0, 0, 0, 0);
        cyc(1, 400, 1, 1, 0, 0);
        for (int k = 0; k < NC; k++) e[k] = 300 + k;
        chk_all("R6 pre-write copy", e);
        for (int k = 1; k < NC; k++) cyc(1, 400 + k, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        for (int k = 0; k < NC; k++) e[k] = 400 + k;
        chk_all("R6 next group", e);
    endtask

    task automatic t_overflow();
        int e [NC];
        for (int k = 0; k < NC; k++) cyc(1, 500 + k, k == 0, 0, 0, 0);
        chk("R7 no ovf at six", int'(ovf), 0);
        cyc(1, 999, 0, 0, 0, 0);
        chk("R7 ovf set", int'(ovf), 1);
        cyc(1, 998, 0, 0, 0, 0);
        idle();
        chk("R7 ovf sticky", int'(ovf), 1);
        cyc(0, 0, 0, 1, 0, 0);
        for (int k = 0; k < NC; k++) e[k] = 500 + k;
        chk_all("R7 extra words dropped", e);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R7 ovf cleared by start", int'(ovf), 0);
    endtask

    task automatic t_restart();
        int e [NC];
        cyc(1, 600, 1, 0, 0, 0);
        cyc(1, 601, 0, 0, 0, 0);
        cyc(1, 602, 0, 0, 0, 0);
        cyc(1, 700, 1, 0, 0, 0);
        for (int k = 1; k < NC; k++) cyc(1, 700 + k, 0, 0, 0, 0);
        chk("R10 six accepted after restart", int'(ovf), 0);
        cyc(0, 0, 0, 1, 0, 0);
        for (int k = 0; k < NC; k++) e[k] = 700 + k;
        chk_all("R10 restart order", e);
    endtask

    task automatic t_polarity();
        cyc(0, 0, 0, 0, 0, 1);
        chk("R8 inv ignored without copy", int'(pol), 0);
        cyc(0, 0, 0, 1, 0, 1);
        chk("R8 inv captured", int'(pol), 1);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R8 pol holds", int'(pol), 1);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R8 pol cleared on copy", int'(pol), 0);
    endtask

    // Falling-edge mode: bus is corrupted after the falling edge.
    task automatic t_falling();
        int e [NC];
        edge_sel = 0;
        idle();
        cyc(1, 800, 1, 0, 1, 0);
        for (int k = 1; k < NC; k++) cyc(1, 800 + k, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 1);
        for (int k = 0; k < NC; k++) e[k] = 805 - k;
        chk_all("R9 falling-edge sample", e);
        chk("R9 falling-edge inv", int'(pol), 1);
        edge_sel = 1;
        idle();
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; edge_sel = 1; dir = 0; start = 0; xfer = 0;
        inv = 0; vld = 0; pix = '0;
        t_reset();
        t_forward();
        t_reverse();
        t_overlap();
        t_overflow();
        t_restart();
        t_polarity();
        t_falling();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule